// File: doc/BRIEF.md
# Fused Combine-and-Scan Descriptor Legality Checker

This block screens one 64-byte command descriptor for the fused two-tensor combine followed by an inclusive prefix scan. The descriptor arrives as a flat byte vector on a request strobe. The block decodes its fixed field layout and applies every legality rule of that command. One clock later it returns a single accept flag and a fail vector that holds one bit per rule, so the issuing logic can drop the command or report exactly why it was refused.

Byte k of the descriptor occupies bits [8k+7:8k] of the request vector. Multi-byte fields are little endian. The checker does not execute the command and does not test address ranges. The only part of the tensor start address it looks at is the flag that says the shape comes from a register.

Top module: `fsc_desc_check`

## Requirements
- R1: A request on `req_valid` produces `rsp_valid` on the next rising clock edge, one response per request. When no response is due, `rsp_valid`, `rsp_accept` and `rsp_fail` are all zero, and reset (synchronous, active high) puts them in that state.
- R2: `rsp_accept` is high on a response exactly when every bit of `rsp_fail` is zero.
- R3: Fail bit 0 is set when byte 0 (the opcode) is not 0xE5.
- R4: Fail bit 1 checks byte 36 and fail bit 2 checks byte 37. Each bit is set unless its operator code is one of 0x00, 0x04, 0x05, 0x06, 0x08, 0x09, 0x0D, 0x0E, 0x0F, 0x12–0x19 or 0x20–0x23. Divide, power, modulo, reciprocal square root and every code from 0xC4 upward are therefore refused.
- R5: Fail bit 3 is set when the operand-order byte 38 is above 3. Fail bit 5 is set when any of bytes 45, 46 or 47 is nonzero.
- R6: Fail bit 4 is set when the accumulator-mode byte 44 is nonzero (idle = 0). Codes 1 to 4 and all others are refused.
- R7: A data-type code is valid when it lies in 0x1–0xF. Fail bit 6 checks the low nibble of byte 40 (first input), fail bit 7 checks the high nibble of byte 40 (second input), and fail bit 8 checks byte 43 (scalar). On these three, code 0xB (rounded FP32) is also refused. Fail bit 9 checks the output type in byte 41, where 0xB is allowed.
- R8: Fail bit 10 is set when the scalar-source byte 39 is above 2 (0 inline, 1 pointer, 2 register pointer). Fail bit 11 is set when the source is inline (0) and the scalar type in byte 43 is not FP32 (0xA).
- R9: Fail bit 12 is set when the channel-count byte 42 is 0 or greater than 128.
- R10: The three tensor patterns start at bytes 12 (first input), 24 (second input) and 48 (output). Each pattern has a 4-byte start address at offset 0 and two 16-bit element counts at offsets 8 and 10, and its element total is the product of the two counts. Fail bit 13 is set when the totals of the two inputs differ. Fail bit 14 is set when the totals of the first input and the output differ.
- R11: Setting bit 31 of a pattern's start address marks its shape as register-sourced. Any total comparison that involves such a pattern is waived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Descriptor present this cycle |
| req_desc | input | 512 | Descriptor bytes, byte k at bits [8k+7:8k] |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_accept | output | 1 | Descriptor is legal |
| rsp_fail | output | 15 | One bit per violated rule |

## Verification
The bench aims at the edges of each range. It checks channel counts of 0, 1, 128 and 129, accumulator codes 1 to 4, an operator at 0xC4, and rounded FP32 placed on the output versus on an input. A checker with an off-by-one limit, or one that applied the output rule to the inputs, would flip accept on exactly these cases. Element totals are arranged so that the products match while the individual counts do not. That catches a design comparing counts field by field, or treating the two 16-bit counts as a single word. The bench also tests the register-shape waiver on each side of a comparison, and an inline scalar of the wrong type against a pointer-sourced scalar of the same type. A design that waived only one side, or applied the FP32 rule regardless of source, would report false failures.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int RULE_N      = 15;
  localparam int RB_OPCODE   = 0;
  localparam int RB_OP0      = 1;
  localparam int RB_OP1      = 2;
  localparam int RB_REV      = 3;
  localparam int RB_ACCUM    = 4;
  localparam int RB_RSVD     = 5;
  localparam int RB_DT_IN0   = 6;
  localparam int RB_DT_IN1   = 7;
  localparam int RB_DT_SCL   = 8;
  localparam int RB_DT_OUT   = 9;
  localparam int RB_SCL_SRC  = 10;
  localparam int RB_SCL_FP32 = 11;
  localparam int RB_CHAN     = 12;
  localparam int RB_CNT_01   = 13;
  localparam int RB_CNT_0D   = 14;

  // byte positions that the command decoder downstream relies on
  localparam int BY_OPCODE = 0;
  localparam int BY_PAT0   = 12;
  localparam int BY_PAT1   = 24;
  localparam int BY_OP0    = 36;
  localparam int BY_OP1    = 37;
  localparam int BY_REV    = 38;
  localparam int BY_SSRC   = 39;
  localparam int BY_DTIN   = 40;
  localparam int BY_DTOUT  = 41;
  localparam int BY_CHAN   = 42;
  localparam int BY_DTSCL  = 43;
  localparam int BY_ACCUM  = 44;
  localparam int BY_RSVD   = 45;
  localparam int BY_PATD   = 48;

  localparam logic [7:0] OPC_SCAN   = 8'hE5;
  localparam logic [7:0] DT_FP32    = 8'h0A;
  localparam logic [7:0] DT_FP32R   = 8'h0B;
  localparam logic [7:0] SSRC_INL   = 8'd0;
  localparam logic [7:0] SSRC_MAX   = 8'd2;
  localparam logic [7:0] REV_MAX    = 8'd3;

  typedef logic [RULE_N-1:0] fail_vec_t;
endpackage

// File: rtl/fsc_pat_decode.sv
module fsc_pat_decode #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 16,
  localparam int PAT_W = ADDR_W + 2*STEP_W + 2*CNT_W,
  localparam int TOT_W = 2*CNT_W
) (
  input  logic [PAT_W-1:0] pat,
  output logic [TOT_W-1:0] total,
  output logic             from_reg
);
  localparam int CNT_LO = ADDR_W + 2*STEP_W;
  logic [CNT_W-1:0] cnt_a, cnt_b;

  always_comb begin
    cnt_a    = pat[CNT_LO +: CNT_W];
    cnt_b    = pat[CNT_LO+CNT_W +: CNT_W];
    from_reg = pat[ADDR_W-1];
    total    = TOT_W'(cnt_a) * TOT_W'(cnt_b);
  end
endmodule

// File: rtl/fsc_op_check.sv
module fsc_op_check (
  input  logic [7:0] op,
  output logic       ok
);
  always_comb begin
    unique case (op) inside
      8'h00, 8'h04, 8'h05, 8'h06, 8'h08, 8'h09,
      8'h0D, 8'h0E, 8'h0F,
      [8'h12:8'h19],
      [8'h20:8'h23]: ok = 1'b1;
      default:       ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsc_dtype_check.sv
module fsc_dtype_check #(
  parameter bit ALLOW_ROUNDED = 1'b0
) (
  input  logic [7:0] code,
  output logic       ok
);
  logic in_range;
  always_comb begin
    in_range = (code != 8'd0) && (code <= 8'h0F);
    if (ALLOW_ROUNDED) ok = in_range;
    else               ok = in_range && (code != fsc_pkg::DT_FP32R);
  end
endmodule

// File: rtl/fsc_desc_check.sv
module fsc_desc_check #(
  parameter int DESC_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int STEP_W     = 16,
  parameter int CNT_W      = 16,
  parameter int MAX_CHAN   = 128,
  parameter int RSVD_N     = 3,
  localparam int DESC_W    = DESC_BYTES*8,
  localparam int PAT_W     = ADDR_W + 2*STEP_W + 2*CNT_W,
  localparam int TOT_W     = 2*CNT_W,
  localparam int NRULE     = fsc_pkg::RULE_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [DESC_W-1:0] req_desc,
  output logic              rsp_valid,
  output logic              rsp_accept,
  output logic [NRULE-1:0]  rsp_fail
);
  import fsc_pkg::*;

  localparam int NPAT = 3;
  localparam int NDT  = 4;
  localparam int PAT_BASE [NPAT] = '{BY_PAT0, BY_PAT1, BY_PATD};

  function automatic logic [7:0] byte_at(input logic [DESC_W-1:0] d, input int idx);
    return d[idx*8 +: 8];
  endfunction

  // tensor pattern decode
  logic [TOT_W-1:0] tot  [NPAT];
  logic             sreg [NPAT];
  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    fsc_pat_decode #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_pat (
      .pat      (req_desc[PAT_BASE[p]*8 +: PAT_W]),
      .total    (tot[p]),
      .from_reg (sreg[p])
    );
  end

  // operator selectors
  localparam int OP_BY [2] = '{BY_OP0, BY_OP1};
  logic op_ok [2];
  for (genvar o = 0; o < 2; o++) begin : g_op
    fsc_op_check u_op (.op(req_desc[OP_BY[o]*8 +: 8]), .ok(op_ok[o]));
  end

  // data types: 0 = in0 nibble, 1 = in1 nibble, 2 = scalar, 3 = output
  logic [7:0] dt_code [NDT];
  logic       dt_ok   [NDT];
  always_comb begin
    dt_code[0] = {4'd0, req_desc[BY_DTIN*8 +: 4]};
    dt_code[1] = {4'd0, req_desc[BY_DTIN*8+4 +: 4]};
    dt_code[2] = req_desc[BY_DTSCL*8 +: 8];
    dt_code[3] = req_desc[BY_DTOUT*8 +: 8];
  end
  for (genvar t = 0; t < NDT; t++) begin : g_dt
    fsc_dtype_check #(.ALLOW_ROUNDED(t == NDT-1)) u_dt (.code(dt_code[t]), .ok(dt_ok[t]));
  end

  logic [7:0]       chan, ssrc;
  logic [RSVD_N*8-1:0] rsvd;
  fail_vec_t        fail_d;

  always_comb begin
    chan   = byte_at(req_desc, BY_CHAN);
    ssrc   = byte_at(req_desc, BY_SSRC);
    rsvd   = req_desc[BY_RSVD*8 +: RSVD_N*8];
    fail_d = '0;
    fail_d[RB_OPCODE]   = byte_at(req_desc, BY_OPCODE) != OPC_SCAN;
    fail_d[RB_OP0]      = !op_ok[0];
    fail_d[RB_OP1]      = !op_ok[1];
    fail_d[RB_REV]      = byte_at(req_desc, BY_REV) > REV_MAX;
    fail_d[RB_ACCUM]    = byte_at(req_desc, BY_ACCUM) != 8'd0;
    fail_d[RB_RSVD]     = |rsvd;
    fail_d[RB_DT_IN0]   = !dt_ok[0];
    fail_d[RB_DT_IN1]   = !dt_ok[1];
    fail_d[RB_DT_SCL]   = !dt_ok[2];
    fail_d[RB_DT_OUT]   = !dt_ok[3];
    fail_d[RB_SCL_SRC]  = ssrc > SSRC_MAX;
    fail_d[RB_SCL_FP32] = (ssrc == SSRC_INL) && (dt_code[2] != DT_FP32);
    fail_d[RB_CHAN]     = (chan == 8'd0) || (int'(chan) > MAX_CHAN);
    fail_d[RB_CNT_01]   = !(sreg[0] || sreg[1]) && (tot[0] != tot[1]);
    fail_d[RB_CNT_0D]   = !(sreg[0] || sreg[2]) && (tot[0] != tot[2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_fail   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_accept <= req_valid && (fail_d == '0);
      rsp_fail   <= req_valid ? fail_d : '0;
    end
  end
endmodule

// File: rtl/fsc_desc_check_sva.sv
module fsc_desc_check_sva #(
  parameter int DESC_BYTES = 64,
  parameter int NRULE      = 15
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [DESC_BYTES*8-1:0] req_desc,
  input logic                  rsp_valid,
  input logic                  rsp_accept,
  input logic [NRULE-1:0]      rsp_fail
);
  // R1
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_fail == '0) && !rsp_accept);
  // R2
  a_r2_accept_clean: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_accept == (rsp_fail == '0)));
  // R3
  a_r3_bad_opcode: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_desc[7:0] != 8'hE5) |=> rsp_fail[0] && !rsp_accept);
  // R6
  a_r6_accum_idle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_desc[44*8 +: 8] != 8'd0) |=> rsp_fail[4]);
  // R9
  a_r9_zero_chan: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_desc[42*8 +: 8] == 8'd0) |=> rsp_fail[12]);
  // R5
  a_r5_reserved: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_desc[45*8 +: 24] != 24'd0) |=> rsp_fail[5]);
endmodule

bind fsc_desc_check fsc_desc_check_sva #(.DESC_BYTES(DESC_BYTES), .NRULE(NRULE)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_desc(req_desc),
  .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_fail(rsp_fail)
);

// File: tb/fsc_desc_check_bench.sv
module fsc_desc_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [511:0]  req_desc = '0;
  logic          rsp_valid, rsp_accept;
  logic [NR-1:0] rsp_fail;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsc_desc_check u_fsc_desc_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_desc(req_desc),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_fail(rsp_fail)
  );

  function automatic logic [7:0] gb(input logic [511:0] d, input int i);
    return d[i*8 +: 8];
  endfunction
  function automatic logic [511:0] sb(input logic [511:0] d, input int i, input logic [7:0] v);
    logic [511:0] r = d; r[i*8 +: 8] = v; return r;
  endfunction
  function automatic logic [511:0] s16(input logic [511:0] d, input int i, input logic [15:0] v);
    logic [511:0] r = d; r[i*8 +: 16] = v; return r;
  endfunction

  function automatic bit op_legal(input logic [7:0] op);
    return op inside {8'h00, 8'h04, 8'h05, 8'h06, 8'h08, 8'h09, 8'h0D, 8'h0E, 8'h0F,
                      [8'h12:8'h19], [8'h20:8'h23]};
  endfunction
  function automatic bit dt_legal(input logic [7:0] c, input bit rounded_ok);
    return c >= 8'h01 && c <= 8'h0F && (rounded_ok || c != 8'h0B);
  endfunction
  function automatic longint pat_tot(input logic [511:0] d, input int base);
    return longint'(d[(base+8)*8 +: 16]) * longint'(d[(base+10)*8 +: 16]);
  endfunction
  function automatic bit pat_reg(input logic [511:0] d, input int base);
    return d[base*8 + 31];
  endfunction

  function automatic logic [NR-1:0] exp_fail(input logic [511:0] d);
    logic [NR-1:0] f = '0;
    f[0]  = gb(d,0) != 8'hE5;
    f[1]  = !op_legal(gb(d,36));
    f[2]  = !op_legal(gb(d,37));
    f[3]  = gb(d,38) > 3;
    f[4]  = gb(d,44) != 0;
    f[5]  = (gb(d,45) | gb(d,46) | gb(d,47)) != 0;
    f[6]  = !dt_legal({4'd0, gb(d,40) & 8'h0F}, 0);
    f[7]  = !dt_legal({4'd0, gb(d,40) >> 4}, 0);
    f[8]  = !dt_legal(gb(d,43), 0);
    f[9]  = !dt_legal(gb(d,41), 1);
    f[10] = gb(d,39) > 2;
    f[11] = gb(d,39) == 0 && gb(d,43) != 8'h0A;
    f[12] = gb(d,42) == 0 || gb(d,42) > 128;
    f[13] = !(pat_reg(d,12) || pat_reg(d,24)) && pat_tot(d,12) != pat_tot(d,24);
    f[14] = !(pat_reg(d,12) || pat_reg(d,48)) && pat_tot(d,12) != pat_tot(d,48);
    return f;
  endfunction

  localparam logic [7:0] OPS [21] = '{8'h00,8'h04,8'h05,8'h06,8'h08,8'h09,8'h0D,8'h0E,8'h0F,
    8'h12,8'h13,8'h14,8'h15,8'h16,8'h17,8'h18,8'h19,8'h20,8'h21,8'h22,8'h23};

  function automatic logic [7:0] rnd_dt();
    logic [7:0] v = 8'(1 + $urandom % 14);
    if (v >= 8'h0B) v = v + 1;
    return v;
  endfunction

  function automatic logic [511:0] legal_desc();
    logic [511:0] d;
    logic [15:0] a, b;
    for (int i = 0; i < 16; i++) d[i*32 +: 32] = $urandom;
    a = 16'(1 + $urandom % 200);
    b = 16'(1 + $urandom % 200);
    d = sb(d, 0, 8'hE5);
    d = sb(d, 15, gb(d,15) & 8'h7F);
    d = sb(d, 27, gb(d,27) & 8'h7F);
    d = sb(d, 51, gb(d,51) & 8'h7F);
    d = s16(d, 20, a); d = s16(d, 22, b);
    d = s16(d, 32, b); d = s16(d, 34, a);
    d = s16(d, 56, a*b); d = s16(d, 58, 16'd1);
    d = sb(d, 36, OPS[$urandom % 21]);
    d = sb(d, 37, OPS[$urandom % 21]);
    d = sb(d, 38, 8'($urandom % 4));
    d = sb(d, 40, {rnd_dt()[3:0], rnd_dt()[3:0]});
    d = sb(d, 41, 8'(1 + $urandom % 15));
    d = sb(d, 42, 8'(1 + $urandom % 128));
    d = sb(d, 44, 8'd0);
    d = sb(d, 45, 8'd0); d = sb(d, 46, 8'd0); d = sb(d, 47, 8'd0);
    if ($urandom % 2 == 0) begin d = sb(d, 39, 8'd0); d = sb(d, 43, 8'h0A); end
    else begin d = sb(d, 39, 8'(1 + $urandom % 2)); d = sb(d, 43, rnd_dt()); end
    return d;
  endfunction

  task automatic run(input logic [511:0] d, input string tag);
    logic [NR-1:0] ef;
    ef = exp_fail(d);
    @(negedge clk);
    req_valid = 1'b1; req_desc = d;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_fail !== ef || rsp_accept !== (ef == '0)) begin
      failures++;
      $display("FAIL %s valid=%0b fail=%h accept=%0b expected valid=1 fail=%h accept=%0b",
               tag, rsp_valid, rsp_fail, rsp_accept, ef, (ef == '0));
    end
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fail !== '0 || rsp_accept !== 1'b0) begin
      failures++;
      $display("FAIL %s idle valid=%0b fail=%h accept=%0b expected 0 0 0",
               tag, rsp_valid, rsp_fail, rsp_accept);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [511:0] d;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    // directed corner cases
    d = legal_desc(); run(d, "R2 legal accept");
    run(sb(legal_desc(), 0, 8'hE6), "R3 opcode E6");
    run(sb(legal_desc(), 36, 8'hC4), "R4 op0 C4");
    run(sb(legal_desc(), 37, 8'h07), "R4 op1 divide-range code");
    run(sb(legal_desc(), 36, 8'h23), "R4 op0 23 allowed");
    run(sb(legal_desc(), 38, 8'd4), "R5 reverse 4");
    run(sb(legal_desc(), 46, 8'h01), "R5 reserved byte");
    for (int k = 1; k <= 4; k++) run(sb(legal_desc(), 44, 8'(k)), "R6 accum code");
    d = legal_desc(); run(sb(d, 41, 8'h0B), "R7 rounded on output ok");
    d = legal_desc(); run(sb(d, 40, {gb(d,40)[7:4], 4'hB}), "R7 rounded on in0");
    d = legal_desc(); run(sb(d, 40, {4'h0, gb(d,40)[3:0]}), "R7 zero in1");
    d = legal_desc(); d = sb(d, 39, 8'd1); run(sb(d, 43, 8'h0B), "R7 rounded scalar");
    run(sb(legal_desc(), 39, 8'd3), "R8 scalar source 3");
    d = legal_desc(); d = sb(d, 39, 8'd0); run(sb(d, 43, 8'h07), "R8 inline non-fp32");
    d = legal_desc(); d = sb(d, 39, 8'd1); run(sb(d, 43, 8'h07), "R8 pointer fp16 ok");
    run(sb(legal_desc(), 42, 8'd0), "R9 chan 0");
    run(sb(legal_desc(), 42, 8'd1), "R9 chan 1");
    run(sb(legal_desc(), 42, 8'd128), "R9 chan 128");
    run(sb(legal_desc(), 42, 8'd129), "R9 chan 129");
    d = legal_desc(); d = s16(d, 20, 16'd6); d = s16(d, 22, 16'd4);
    d = s16(d, 32, 16'd3); d = s16(d, 34, 16'd8); d = s16(d, 56, 16'd24);
    run(d, "R10 equal products differing counts");
    run(s16(d, 32, 16'd5), "R10 src1 mismatch");
    run(s16(d, 56, 16'd25), "R10 dst mismatch");
    run(sb(s16(d, 56, 16'd25), 51, 8'h80), "R11 dst reg waiver");
    run(sb(s16(d, 32, 16'd5), 27, 8'h80), "R11 src1 reg waiver");
    run(sb(s16(s16(d, 32, 16'd5), 56, 16'd25), 15, 8'h80), "R11 src0 reg waives both");
    run(sb(d, 27, 8'h80), "R11 flag without mismatch");

    // constrained random with occasional field corruption
    for (int n = 0; n < 400; n++) begin
      d = legal_desc();
      if ($urandom % 3 != 0) begin
        int f = $urandom % 12;
        case (f)
          0:  d = sb(d, 0, 8'($urandom));
          1:  d = sb(d, 36, 8'($urandom));
          2:  d = sb(d, 37, 8'($urandom % 48));
          3:  d = sb(d, 38, 8'($urandom % 8));
          4:  d = sb(d, 44, 8'($urandom % 6));
          5:  d = sb(d, 45 + $urandom % 3, 8'($urandom % 2));
          6:  d = sb(d, 40, 8'($urandom));
          7:  d = sb(d, 41, 8'($urandom % 20));
          8:  d = sb(d, 43, 8'($urandom % 20));
          9:  d = sb(d, 39, 8'($urandom % 5));
          10: d = sb(d, 42, 8'($urandom));
          default: d = s16(d, 20 + 12*($urandom % 3), 16'($urandom % 300));
        endcase
      end
      run(d, "R2 random");
      if (n % 50 == 0) begin @(negedge clk); check_idle("R1 gap"); end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule